// File: doc/BRIEF.md
# Programmable Multi-Mode Down Timer

This block is one timer channel of a peripheral. It counts a 16-bit value down towards zero. Each step is taken on the falling edge of a clock picked from a prescaler chain that runs from the system clock. Software writes a reload value as two bytes and sets up a control byte and an output configuration byte. Starting the timer copies the reload value into the counter. What happens when the count reaches zero depends on the mode: the output pulses or toggles, the counter either stops or reloads, and an interrupt flag is raised if that is enabled.

Reads of the two data addresses normally return the reload bytes. When the control byte is written with its snapshot bit set, both bytes of the live count are captured in the same cycle. From then on the data reads return that capture, so a two-byte read is always self-consistent. The timer output and the interrupt output each have their own polarity bit. Each also has its own drive-style bit, which selects push-pull or open-drain through an output-enable pin.

All activity is synchronous to `clk`. The prescaler is a free-running counter that is cleared by reset. Address and register decode outside this channel, and interrupt routing, belong to the surrounding chip.

Top module: `downTimer`

## Requirements
- R1: After reset, all registers, the counter and the prescaler are zero. `timerOut` and `irqOut` are 0, both enables are 1, and `rdData` reads 0.
- R2: A write to address 0 sets the low reload byte and a write to address 1 sets the high reload byte. Addresses 2 and 3 hold the control and configuration bytes. With control bit 6 clear, reads of addresses 0 and 1 return the reload bytes.
- R3: A control write with bit 6 set captures the counter value as it stood before that clock edge. While bit 6 stays set, reads of addresses 0 and 1 return the captured low and high bytes.
- R4: A control write that changes bit 5 (run) from 0 to 1 loads the reload value into the counter. It starts counting, except in mode 3. Rewriting the control byte with run already set does not reload the counter.
- R5: The counter decrements once per falling edge of the selected tap. Control bits [4:2] select divide-by 1, 2, 4, 16, 64, 256, 1024 or 4096 for codes 0 to 7. A reload of 0 counts 65536 steps.
- R6: Mode 0 (bits [1:0]=0) is single-shot. The step that takes the count from 1 to 0 makes the internal output level high for exactly the next clock cycle, and counting stops at 0.
- R7: Mode 1 is a rate generator. It gives the same one-cycle pulse at zero, reloads in that same edge and keeps counting, so pulses repeat every reload-value steps.
- R8: Mode 2 is a square wave. At each zero the level toggles and the counter reloads. Starting the timer clears the level to 0.
- R9: Mode 3 is a gated one-shot. With run set, a rising edge on `gateIn` loads and starts the counter. A later rising edge restarts it from the reload value. Zero behaves as in mode 0.
- R10: When configuration bit 4 is set, a zero event sets the interrupt flag. The flag holds until `irqAck` is high at a clock edge. A zero event and an acknowledge in the same cycle leave the flag set.
- R11: Configuration bit 0 inverts `timerOut` and bit 1 inverts `irqOut` (1 = active low).
- R12: Configuration bit 2 (timer) and bit 3 (interrupt) select open-drain. The matching enable is then high only while the level is asserted. In push-pull the enable is always 1.
- R13: A control write with run clear stops counting. The counter holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 reload low, 1 reload high, 2 control, 3 config |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address, same map as writes |
| rdData | output | 8 | Read data (combinational) |
| gateIn | input | 1 | Trigger input for mode 3 |
| irqAck | input | 1 | Clears the interrupt flag |
| timerOut | output | 1 | Timer output after polarity |
| timerOutEn | output | 1 | Timer output drive enable |
| irqOut | output | 1 | Interrupt output after polarity |
| irqOutEn | output | 1 | Interrupt output drive enable |

## Verification
A zero event can set the interrupt flag in the same cycle that software acknowledges it. The bench provokes this by holding `irqAck` high for a whole stretch of rate-generator operation with a short reload, so several zero events land on acknowledge cycles. The reference model lets the set win, and the interrupt pin is compared every clock. Start, stop and snapshot writes are also placed in the middle of counting, where they meet prescaler ticks, and the bench checks that a load or stop takes priority over the step in that cycle.

// File: rtl/timerPkg.sv
package timerPkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2,
    MODE_GATED   = 2'd3
  } timerModeE;

  typedef struct packed {
    logic load;
    logic activate;
    logic halt;
    logic tick;
    logic capture;
  } timerStrobeT;

  localparam int MODE_LSB = 0;
  localparam int SEL_LSB  = 2;
  localparam int SEL_W    = 3;
  localparam int RUN_BIT  = 5;
  localparam int SNAP_BIT = 6;

  localparam int CFG_OUT_LOW = 0;
  localparam int CFG_IRQ_LOW = 1;
  localparam int CFG_OUT_OD  = 2;
  localparam int CFG_IRQ_OD  = 3;
  localparam int CFG_IRQ_EN  = 4;

  // highest prescaler bit watched for a given select code (code 0 = no divide)
  function automatic int tapBit(input logic [SEL_W-1:0] sel);
    return (sel == 1) ? 0 : 2 * int'(sel) - 3;
  endfunction
endpackage

// File: rtl/timerCtrl.sv
module timerCtrl
  import timerPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                gateIn,
  output logic [2*BYTE_W-1:0] reloadVal,
  output logic [BYTE_W-1:0]   ctrlQ,
  output logic [BYTE_W-1:0]   cfgQ,
  output timerStrobeT         stb
);
  logic [PRE_W-1:0] prescQ;
  logic             gatePrev;
  logic [BYTE_W-1:0] reloadLo, reloadHi;
  logic [PRE_W-1:0] tapMask;
  logic ctrlWr, gateRise;
  logic [SEL_W-1:0] selCode;

  assign reloadVal = {reloadHi, reloadLo};
  assign selCode   = ctrlQ[SEL_LSB +: SEL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescQ   <= '0;
      gatePrev <= 1'b0;
      reloadLo <= '0;
      reloadHi <= '0;
      ctrlQ    <= '0;
      cfgQ     <= '0;
    end else begin
      prescQ   <= prescQ + 1'b1;
      gatePrev <= gateIn;
      if (wrEn) begin
        case (wrAddr)
          2'd0: reloadLo <= wrData;
          2'd1: reloadHi <= wrData;
          2'd2: ctrlQ    <= wrData;
          default: cfgQ  <= wrData;
        endcase
      end
    end
  end

  always_comb begin
    tapMask = '0;
    for (int b = 0; b < PRE_W; b++) begin
      if (b <= tapBit(selCode)) tapMask[b] = 1'b1;
    end
  end

  always_comb begin
    ctrlWr   = wrEn && (wrAddr == 2'd2);
    gateRise = gateIn && !gatePrev && ctrlQ[RUN_BIT] &&
               (timerModeE'(ctrlQ[MODE_LSB +: 2]) == MODE_GATED);
    stb          = '0;
    stb.tick     = (selCode == '0) || ((prescQ & tapMask) == tapMask);
    stb.capture  = ctrlWr && wrData[SNAP_BIT];
    stb.halt     = ctrlWr && !wrData[RUN_BIT];
    if (ctrlWr && wrData[RUN_BIT] && !ctrlQ[RUN_BIT]) begin
      stb.load     = 1'b1;
      stb.activate = (timerModeE'(wrData[MODE_LSB +: 2]) != MODE_GATED);
    end
    if (gateRise) begin
      stb.load     = 1'b1;
      stb.activate = 1'b1;
    end
  end
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import timerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerStrobeT      stb,
  input  logic [CNT_W-1:0] reloadVal,
  input  timerModeE        modeQ,
  input  logic             irqEnable,
  input  logic             irqAck,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] snapVal,
  output logic             activeQ,
  output logic             pulseQ,
  output logic             squareQ,
  output logic             irqFlag
);
  logic zeroEvt, autoReload;

  assign autoReload = (modeQ == MODE_RATE) || (modeQ == MODE_SQUARE);
  assign zeroEvt    = activeQ && stb.tick && (cntVal == CNT_W'(1)) &&
                      !stb.load && !stb.halt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal  <= '0;
      snapVal <= '0;
      activeQ <= 1'b0;
      pulseQ  <= 1'b0;
      squareQ <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (stb.capture) snapVal <= cntVal;
      pulseQ <= zeroEvt && (modeQ != MODE_SQUARE);
      if (stb.load) begin
        cntVal  <= reloadVal;
        activeQ <= stb.activate;
        squareQ <= 1'b0;
      end else if (stb.halt) begin
        activeQ <= 1'b0;
      end else if (zeroEvt) begin
        cntVal  <= autoReload ? reloadVal : '0;
        activeQ <= autoReload;
        if (modeQ == MODE_SQUARE) squareQ <= !squareQ;
      end else if (activeQ && stb.tick) begin
        cntVal <= cntVal - 1'b1;
      end
      if (zeroEvt && irqEnable) irqFlag <= 1'b1;
      else if (irqAck)          irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/downTimer.sv
module downTimer
  import timerPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  logic              gateIn,
  input  logic              irqAck,
  output logic              timerOut,
  output logic              timerOutEn,
  output logic              irqOut,
  output logic              irqOutEn
);
  localparam int CNT_W = 2 * BYTE_W;

  timerStrobeT       stb;
  logic [CNT_W-1:0]  reloadVal, cntVal, snapVal;
  logic [BYTE_W-1:0] ctrlQ, cfgQ;
  logic              activeQ, pulseQ, squareQ, irqFlag, outLvl;
  timerModeE         modeQ;
  logic [CNT_W-1:0]  readWord;

  assign modeQ = timerModeE'(ctrlQ[MODE_LSB +: 2]);

  timerCtrl #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gateIn(gateIn), .reloadVal(reloadVal), .ctrlQ(ctrlQ), .cfgQ(cfgQ), .stb(stb)
  );

  timerDatapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal), .modeQ(modeQ),
    .irqEnable(cfgQ[CFG_IRQ_EN]), .irqAck(irqAck), .cntVal(cntVal),
    .snapVal(snapVal), .activeQ(activeQ), .pulseQ(pulseQ), .squareQ(squareQ),
    .irqFlag(irqFlag)
  );

  assign readWord = ctrlQ[SNAP_BIT] ? snapVal : reloadVal;
  always_comb begin
    case (rdAddr)
      2'd0:    rdData = readWord[BYTE_W-1:0];
      2'd1:    rdData = readWord[CNT_W-1:BYTE_W];
      2'd2:    rdData = ctrlQ;
      default: rdData = cfgQ;
    endcase
  end

  assign outLvl     = (modeQ == MODE_SQUARE) ? squareQ : pulseQ;
  assign timerOut   = outLvl ^ cfgQ[CFG_OUT_LOW];
  assign timerOutEn = !cfgQ[CFG_OUT_OD] || outLvl;
  assign irqOut     = irqFlag ^ cfgQ[CFG_IRQ_LOW];
  assign irqOutEn   = !cfgQ[CFG_IRQ_OD] || irqFlag;
endmodule

// File: rtl/downTimerChecker.sv
module downTimerChecker
  import timerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input timerStrobeT      stb,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic             activeQ,
  input logic             pulseQ,
  input logic             irqFlag,
  input logic             irqAck,
  input timerModeE        modeQ
);
  // R4: a load places the reload value in the counter
  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (cntVal == $past(reloadVal)));

  // R13: an idle counter keeps its value unless a load arrives
  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!activeQ && !stb.load) |=> $stable(cntVal));

  // R5: an ordinary step lowers the count by exactly one
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && stb.tick && !stb.load && !stb.halt && cntVal > 1) |=>
      (cntVal == $past(cntVal) - 1'b1));

  // R6: single-shot pulse lasts one cycle
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ && modeQ == MODE_ONESHOT) |=> !pulseQ);

  // R10: the flag is sticky until acknowledged
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqAck) |=> irqFlag);
endmodule

bind downTimer downTimerChecker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/downTimer_tb.sv
module downTimer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic gateIn = 1'b0;
  logic irqAck = 1'b0;
  logic [7:0] rdData;
  logic timerOut, timerOutEn, irqOut, irqOutEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [15:0] mRel, mCnt, mSnap;
  logic [7:0]  mCtrl, mCfg;
  logic        mActive, mPulse, mSq, mIrq, mGatePrev;
  int          mPresc;

  always #(CLK_PERIOD/2) clk = ~clk;

  downTimer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .gateIn(gateIn), .irqAck(irqAck),
    .timerOut(timerOut), .timerOutEn(timerOutEn), .irqOut(irqOut),
    .irqOutEn(irqOutEn)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cycles, got, exp);
    end
  endtask

  task automatic modelReset();
    mRel = '0; mCnt = '0; mSnap = '0; mCtrl = '0; mCfg = '0;
    mActive = 0; mPulse = 0; mSq = 0; mIrq = 0; mGatePrev = 0; mPresc = 0;
  endtask

  function automatic int divOf(input int sel);
    case (sel)
      0: return 1;  1: return 2;  2: return 4;  3: return 16;
      4: return 64; 5: return 256; 6: return 1024; default: return 4096;
    endcase
  endfunction

  // one clock edge of the reference model, using the inputs held across it
  task automatic modelStep();
    int mode, dv;
    logic tk, ld, act, hlt, cap, zero;
    mode = int'(mCtrl[1:0]);
    dv   = divOf(int'(mCtrl[4:2]));
    tk   = (dv == 1) || ((mPresc % dv) == dv - 1);
    ld = 0; act = 0; hlt = 0; cap = 0;
    if (wrEn && wrAddr == 2) begin
      if (wrData[5] && !mCtrl[5]) begin ld = 1; act = (wrData[1:0] != 2'd3); end
      if (!wrData[5]) hlt = 1;
      if (wrData[6]) cap = 1;
    end
    if (gateIn && !mGatePrev && mCtrl[5] && mode == 3) begin ld = 1; act = 1; end
    zero = mActive && tk && (mCnt == 16'd1) && !ld && !hlt;
    if (cap) mSnap = mCnt;
    mPulse = zero && (mode != 2);
    if (ld) begin
      mCnt = mRel; mActive = act; mSq = 0;
    end else if (hlt) begin
      mActive = 0;
    end else if (zero) begin
      if (mode == 1 || mode == 2) mCnt = mRel;
      else begin mCnt = 0; mActive = 0; end
      if (mode == 2) mSq = !mSq;
    end else if (mActive && tk) begin
      mCnt = mCnt - 16'd1;
    end
    if (zero && mCfg[4]) mIrq = 1;
    else if (irqAck) mIrq = 0;
    if (wrEn) begin
      case (wrAddr)
        2'd0: mRel[7:0]  = wrData;
        2'd1: mRel[15:8] = wrData;
        2'd2: mCtrl      = wrData;
        default: mCfg    = wrData;
      endcase
    end
    mGatePrev = gateIn;
    mPresc++;
  endtask

  task automatic compareAll();
    logic lvl;
    logic [15:0] word;
    logic [7:0] expRd;
    lvl  = (mCtrl[1:0] == 2'd2) ? mSq : mPulse;
    word = mCtrl[6] ? mSnap : mRel;
    case (rdAddr)
      2'd0: expRd = word[7:0];
      2'd1: expRd = word[15:8];
      2'd2: expRd = mCtrl;
      default: expRd = mCfg;
    endcase
    check("R6 R7 R8 R9 R11 timerOut", int'(timerOut), int'(lvl ^ mCfg[0]));
    check("R12 timerOutEn", int'(timerOutEn), int'(!mCfg[2] || lvl));
    check("R10 R11 irqOut", int'(irqOut), int'(mIrq ^ mCfg[1]));
    check("R12 irqOutEn", int'(irqOutEn), int'(!mCfg[3] || mIrq));
    check("R2 R3 rdData", int'(rdData), int'(expRd));
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic runFor(input int n);
    for (int i = 0; i < n; i++) begin
      rdAddr = 2'(i % 4);
      step();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 timerOut", int'(timerOut), 0);
    check("R1 timerOutEn", int'(timerOutEn), 1);
    check("R1 irqOut", int'(irqOut), 0);
    check("R1 irqOutEn", int'(irqOutEn), 1);
    check("R1 rdData", int'(rdData), 0);

    // R2 reload bytes read back
    wr(0, 8'h34); wr(1, 8'h12);
    rdAddr = 0; #1 check("R2 low byte", int'(rdData), 8'h34);
    rdAddr = 1; #1 check("R2 high byte", int'(rdData), 8'h12);

    // R6 single-shot, reload 5, divide by 1, interrupt enabled
    wr(0, 8'h05); wr(1, 8'h00); wr(3, 8'h10);
    wr(2, 8'h00); wr(2, 8'h20);
    runFor(4);
    check("R6 no pulse yet", int'(timerOut), 0);
    step();
    check("R6 pulse at fifth step", int'(timerOut), 1);
    step();
    check("R6 pulse one cycle", int'(timerOut), 0);
    check("R10 flag set", int'(irqOut), 1);
    runFor(5);
    irqAck = 1; step(); irqAck = 0;
    check("R10 flag cleared", int'(irqOut), 0);

    // R7 rate generator, reload 3, divide by 2, with a mid-run rewrite (R4)
    wr(0, 8'h03); wr(2, 8'h05); wr(2, 8'h25);
    runFor(20);
    wr(2, 8'h25);
    runFor(20);
    // R3 snapshot stays fixed while counting goes on
    wr(2, 8'h65);
    rdAddr = 0; #1 held = rdData;
    runFor(3);
    rdAddr = 0; #1 check("R3 snapshot stable", int'(rdData), int'(held));
    // R10 acknowledge held through zero events
    irqAck = 1; runFor(30); irqAck = 0;
    runFor(5);
    // R13 stop holds count
    wr(2, 8'h45);
    rdAddr = 0; #1 held = rdData;
    runFor(10);
    wr(2, 8'h45);
    rdAddr = 0; #1 check("R13 held count", int'(rdData), int'(held));

    // R8 square wave, active-low open-drain timer out, open-drain irq
    wr(0, 8'h02); wr(3, 8'h1D); wr(2, 8'h0A); wr(2, 8'h2A);
    runFor(60);
    irqAck = 1; step(); irqAck = 0;

    // R9 gated one-shot
    wr(3, 8'h12); wr(0, 8'h04); wr(2, 8'h03); wr(2, 8'h23);
    runFor(5);
    gateIn = 1; step(); gateIn = 0;
    runFor(2);
    gateIn = 1; step(); gateIn = 0;
    runFor(10);
    gateIn = 1; step(); gateIn = 0;
    runFor(8);

    // R5 prescaler taps
    wr(3, 8'h10); wr(0, 8'h01);
    for (int s = 3; s <= 6; s++) begin
      wr(2, 8'(1 | (s << 2)));
      wr(2, 8'(8'h21 | (s << 2)));
      runFor(divOf(s) * 2 + 20);
      wr(2, 8'(1 | (s << 2)));
    end
    wr(0, 8'h02); wr(2, 8'h1C); wr(2, 8'h3C);
    runFor(8300);
    // R5 reload of zero wraps to a long count
    wr(0, 8'h00); wr(2, 8'h00); wr(2, 8'h20);
    runFor(40);
    wr(2, 8'h40);
    rdAddr = 1; #1 check("R5 zero reload wraps", int'(rdData), 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule